// File: doc/BRIEF.md
# Configuration Security Lock Controller

This block sits between a device programmer port and a small configuration store. The programmer sends one command at a time over a valid/ready handshake: write one word, read one word back, set the security flag, or erase the whole store. The block keeps a security flag next to the store and decides for each command whether it may run. Once the flag is set, read-back and writing are both refused. Only a whole-store erase brings the store back to its erased value and clears the flag, which opens access again.

A refused command still completes its handshake. It returns a one-cycle response with the error bit set and the data field all zeros. Writes and erases hold the port busy for a parameterised number of cycles, and `cmd_ready` stays low for that whole time. The store and the flag model non-volatile cells. They power up erased and unsecured, and a logic reset does not touch them. A write may ask for the flag to be set as it finishes. In that case the flag goes up only when the word has been committed.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: A read (`cmd_op` = 2'b01) accepted while unsecured gives one cycle later a response (`rsp_valid`=1) with `rsp_err`=0 and `rsp_rdata` equal to the word stored at `cmd_addr`.
- R2: A read accepted while `secured`=1 gives one cycle later a response with `rsp_err`=1 and `rsp_rdata` all zeros.
- R3: A write (`cmd_op` = 2'b00) accepted while `secured`=1 gives one cycle later a response with `rsp_err`=1. It does not lower `cmd_ready` and leaves the store unchanged.
- R4: A write accepted while unsecured holds `cmd_ready` low for exactly PROG_CYC cycles. It then stores `cmd_wdata` at `cmd_addr` and responds with `rsp_err`=0 in the cycle `cmd_ready` returns high, PROG_CYC+1 cycles after acceptance.
- R5: A write accepted with `cmd_lock`=1 while unsecured keeps `secured` at 0 throughout its busy time. It raises `secured` in the same cycle as its response.
- R6: A set-security command (`cmd_op` = 2'b10) responds one cycle after acceptance with `rsp_err`=0, whether or not the flag was already set, and leaves `secured`=1.
- R7: An erase (`cmd_op` = 2'b11) is accepted in either flag state. It holds `cmd_ready` low for exactly ERASE_CYC cycles, then sets every word to all ones, clears `secured` and responds with `rsp_err`=0.
- R8: While `cmd_ready` is low, `cmd_valid` is ignored. No response is produced for it and the store and flag are unaffected.
- R9: Asserting `rst_n` low returns `cmd_ready` to 1 and `rsp_valid` to 0. The stored words and the `secured` flag keep their values across the reset.
- R10: Each accepted command produces exactly one single-cycle `rsp_valid` pulse. `rsp_rdata` is all zeros on every response other than an unsecured read, and while no response is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low logic reset (store and flag excluded) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_op | input | 2 | 00 write, 01 read, 10 set security, 11 erase all |
| cmd_addr | input | AW | Word address for write and read |
| cmd_wdata | input | DW | Word to write |
| cmd_lock | input | 1 | On a write: set the security flag when the write completes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Command refused by the security flag |
| rsp_rdata | output | DW | Read data, all zeros unless an unsecured read |
| secured | output | 1 | Current security flag |

## Verification
The main function, gating by the flag, is tried with every operation in both flag states. The flag is set once by the lock-on-completion write and once by the stand-alone command, so the two ways of setting it are told apart. Reads after an erase return all ones in words that held other data, which separates a real erase from a merely cleared flag. Directed cases then check the exact busy length, that no flag appears before a locked write commits, that a command pulsed during an erase is dropped, and that a reset keeps both data and flag.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'b00,
      OP_READ   = 2'b01,
      OP_SECURE = 2'b10,
      OP_ERASE  = 2'b11
   } cl_op_e;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_REPLY = 2'd1,
      ACT_WRITE = 2'd2,
      ACT_ERASE = 2'd3
   } cl_act_e;

   typedef struct packed {
      cl_act_e act;
      logic    err;
      logic    show_data;
      logic    set_now;
   } cl_decision_t;

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
   import cfg_lock_pkg::*;
(
   input  logic         fire,
   input  logic [1:0]   op,
   input  logic         secured,
   output cl_decision_t dec
);

   always_comb begin
      dec = '{act: ACT_NONE, err: 1'b0, show_data: 1'b0, set_now: 1'b0};
      if (fire) begin
         unique case (cl_op_e'(op))
            OP_READ: begin
               dec.act       = ACT_REPLY;
               dec.err       = secured;
               dec.show_data = !secured;
            end
            OP_WRITE: begin
               if (secured) begin
                  dec.act = ACT_REPLY;
                  dec.err = 1'b1;
               end else begin
                  dec.act = ACT_WRITE;
               end
            end
            OP_SECURE: begin
               dec.act     = ACT_REPLY;
               dec.set_now = 1'b1;
            end
            OP_ERASE: begin
               dec.act = ACT_ERASE;
            end
            default: dec.act = ACT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/cfg_lock_timer.sv
module cfg_lock_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          busy,
   output logic          done
);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         cnt_q  <= load_val - CW'(1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - CW'(1);
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          erase,
   input  logic          set_sec,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          secured
);

   logic [DW-1:0] words [DEPTH];
   logic          sec_q = 1'b0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DW-1:0] word_q = '1;
      always_ff @(posedge clk) begin
         if (erase)
            word_q <= '1;
         else if (wr_en && (wr_addr == AW'(i)))
            word_q <= wr_data;
      end
      assign words[i] = word_q;
   end

   always_ff @(posedge clk) begin
      if (erase)        sec_q <= 1'b0;
      else if (set_sec) sec_q <= 1'b1;
   end

   assign rd_data = words[rd_addr];
   assign secured = sec_q;

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
   import cfg_lock_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int DW        = 16,
   parameter int PROG_CYC  = 3,
   parameter int ERASE_CYC = 5,
   localparam int AW       = $clog2(DEPTH),
   localparam int MAXC     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
   localparam int CW       = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [1:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   input  logic          cmd_lock,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [DW-1:0] rsp_rdata,
   output logic          secured
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cfg_lock_ctrl: DEPTH must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("cfg_lock_ctrl: DW must be positive");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cycles
      $error("cfg_lock_ctrl: PROG_CYC and ERASE_CYC must be at least 1");
   end

   logic          fire;
   cl_decision_t  dec;
   logic          busy, done, load;
   logic [CW-1:0] load_val;
   logic          pend_erase_q, pend_lock_q;
   logic [AW-1:0] pend_addr_q;
   logic [DW-1:0] pend_data_q;
   logic [DW-1:0] store_rd;
   logic          st_wr, st_erase, st_set;
   logic          rsp_valid_q, rsp_err_q;
   logic [DW-1:0] rsp_rdata_q;

   assign cmd_ready = !busy;
   assign fire      = cmd_valid && cmd_ready;

   cfg_lock_decode u_dec (
      .fire    (fire),
      .op      (cmd_op),
      .secured (secured),
      .dec     (dec)
   );

   assign load     = (dec.act == ACT_WRITE) || (dec.act == ACT_ERASE);
   assign load_val = (dec.act == ACT_ERASE) ? CW'(ERASE_CYC) : CW'(PROG_CYC);

   cfg_lock_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .busy     (busy),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_erase_q <= 1'b0;
         pend_lock_q  <= 1'b0;
         pend_addr_q  <= '0;
         pend_data_q  <= '0;
      end else if (load) begin
         pend_erase_q <= (dec.act == ACT_ERASE);
         pend_lock_q  <= cmd_lock && (dec.act == ACT_WRITE);
         pend_addr_q  <= cmd_addr;
         pend_data_q  <= cmd_wdata;
      end
   end

   assign st_wr    = done && !pend_erase_q;
   assign st_erase = done &&  pend_erase_q;
   assign st_set   = dec.set_now || (st_wr && pend_lock_q);

   cfg_lock_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .wr_en   (st_wr),
      .wr_addr (pend_addr_q),
      .wr_data (pend_data_q),
      .erase   (st_erase),
      .set_sec (st_set),
      .rd_addr (cmd_addr),
      .rd_data (store_rd),
      .secured (secured)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else if (dec.act == ACT_REPLY) begin
         rsp_valid_q <= 1'b1;
         rsp_err_q   <= dec.err;
         rsp_rdata_q <= dec.show_data ? store_rd : '0;
      end else if (done) begin
         rsp_valid_q <= 1'b1;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/cfg_lock_ctrl_chk.sv
module cfg_lock_ctrl_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [1:0]    cmd_op,
   input logic          rsp_valid,
   input logic          rsp_err,
   input logic [DW-1:0] rsp_rdata,
   input logic          secured
);

   logic acc;
   assign acc = cmd_valid && cmd_ready;

   p_read_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 2'b01 && !secured) |=> (rsp_valid && !rsp_err));

   p_read_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 2'b01 && secured) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

   p_write_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 2'b00 && secured) |=> (rsp_valid && rsp_err && cmd_ready));

   p_lock_at_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(secured) |-> (rsp_valid && !rsp_err));

   p_erase_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(secured) |-> (rsp_valid && !rsp_err && cmd_ready));

   p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> !rsp_valid);

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_valid || rsp_err) |-> (rsp_rdata == '0));

   p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(acc) || $past(!cmd_ready)));

endmodule

bind cfg_lock_ctrl cfg_lock_ctrl_chk #(.DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .secured   (secured)
);

// File: tb/cfg_lock_ctrl_tb.sv
module cfg_lock_ctrl_tb_top;

   localparam int CLK_P = 10;
   localparam int DEPTH = 8;
   localparam int DW    = 16;
   localparam int PROG  = 3;
   localparam int ERASE = 5;
   localparam int AW    = 3;
   localparam int NVEC  = 17;

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic          lock;
      logic          e_err;
      logic [DW-1:0] e_rd;
      logic          e_sec;
   } vec_t;

   // op: 0 write, 1 read, 2 set security, 3 erase
   localparam vec_t VECS [NVEC] = '{
      {2'd3, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
      {2'd1, 3'd2, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      {2'd0, 3'd2, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0},
      {2'd1, 3'd2, 16'h0000, 1'b0, 1'b0, 16'h1234, 1'b0},
      {2'd0, 3'd5, 16'hABCD, 1'b1, 1'b0, 16'h0000, 1'b1},
      {2'd1, 3'd5, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1},
      {2'd0, 3'd2, 16'h5555, 1'b0, 1'b1, 16'h0000, 1'b1},
      {2'd3, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
      {2'd1, 3'd2, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      {2'd1, 3'd5, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      {2'd0, 3'd7, 16'h0F0F, 1'b0, 1'b0, 16'h0000, 1'b0},
      {2'd2, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      {2'd2, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      {2'd1, 3'd7, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1},
      {2'd3, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
      {2'd1, 3'd7, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      {2'd0, 3'd0, 16'hBEEF, 1'b0, 1'b0, 16'h0000, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_lock = 1'b0;
   logic          rsp_valid, rsp_err, secured;
   logic [DW-1:0] rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   cfg_lock_ctrl #(.DEPTH(DEPTH), .DW(DW), .PROG_CYC(PROG), .ERASE_CYC(ERASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_lock(cmd_lock),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .secured(secured)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic lk,
                         output logic e, output logic [DW-1:0] rd,
                         output int lat, output int lowc, output logic secb);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_lock = lk;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_lock = 1'b0;
      lat = 1; lowc = 0; secb = 1'b0;
      while (!rsp_valid && lat < 200) begin
         if (!cmd_ready) begin
            lowc++;
            secb |= secured;
         end
         @(negedge clk);
         lat++;
      end
      e  = rsp_err;
      rd = rsp_rdata;
   endtask

   function automatic string req_of(input logic [1:0] op, input logic err);
      case (op)
         2'd1:    return err ? "R2" : "R1";
         2'd0:    return err ? "R3" : "R4";
         2'd2:    return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic          e, secb;
      logic [DW-1:0] rd;
      int            lat, lowc, exp_lat, nrsp;
      string         rq;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "ready after reset", int'(cmd_ready), 1);
      chk("R9", "rsp_valid after reset", int'(rsp_valid), 0);

      for (int i = 0; i < NVEC; i++) begin
         do_cmd(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].lock, e, rd, lat, lowc, secb);
         rq = req_of(VECS[i].op, VECS[i].e_err);
         if (VECS[i].op == 2'd3)                          exp_lat = ERASE + 1;
         else if (VECS[i].op == 2'd0 && !VECS[i].e_err) exp_lat = PROG + 1;
         else                                            exp_lat = 1;
         chk(rq, "err", int'(e), int'(VECS[i].e_err));
         chk(rq, "rdata (R10 zero unless open read)", int'(rd), int'(VECS[i].e_rd));
         chk(rq, "secured", int'(secured), int'(VECS[i].e_sec));
         chk(rq, "latency", lat, exp_lat);
         chk(rq, "busy cycles", lowc, exp_lat - 1);
      end

      // R5: locked write keeps flag low during busy, raises it at commit
      do_cmd(2'd0, 3'd3, 16'hC3C3, 1'b1, e, rd, lat, lowc, secb);
      chk("R5", "secured seen during busy", int'(secb), 0);
      chk("R5", "secured at response", int'(secured), 1);

      // R9: reset keeps flag and data
      do_reset();
      chk("R9", "ready after mid reset", int'(cmd_ready), 1);
      chk("R9", "rsp_valid after mid reset", int'(rsp_valid), 0);
      chk("R9", "secured kept over reset", int'(secured), 1);
      do_cmd(2'd1, 3'd3, 16'h0, 1'b0, e, rd, lat, lowc, secb);
      chk("R2", "read refused after reset", int'(e), 1);
      do_cmd(2'd3, 3'd0, 16'h0, 1'b0, e, rd, lat, lowc, secb);
      chk("R7", "erase while secured clears flag", int'(secured), 0);
      do_cmd(2'd0, 3'd1, 16'h1111, 1'b0, e, rd, lat, lowc, secb);
      do_reset();
      do_cmd(2'd1, 3'd1, 16'h0, 1'b0, e, rd, lat, lowc, secb);
      chk("R9", "word kept over reset", int'(rd), 16'h1111);

      // R8: command pulsed while busy is dropped
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      nrsp = 0;
      for (int c = 0; c < ERASE + 4; c++) begin
         if (c == 1) begin
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 3'd1; cmd_wdata = 16'h0000; cmd_lock = 1'b1;
         end else begin
            cmd_valid = 1'b0; cmd_lock = 1'b0;
         end
         @(negedge clk);
         if (rsp_valid) nrsp++;
      end
      chk("R8", "responses during erase window", nrsp, 1);
      chk("R8", "flag untouched by dropped write", int'(secured), 0);
      do_cmd(2'd1, 3'd1, 16'h0, 1'b0, e, rd, lat, lowc, secb);
      chk("R8", "word untouched by dropped write", int'(rd), 16'hFFFF);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule